// File: doc/BRIEF.md
# Split-Aware Fixed-Priority Bus Arbiter

This block decides which bus master owns the next address phase of a shared
pipelined system bus. Each master raises a request line and may raise a lock
line. The block returns a one-hot grant vector, the index of the master that
owns the current address phase, and a qualified lock flag for that address
phase. Slot 0 belongs to a placeholder master that only ever issues idle
transfers. This leaves up to fifteen real masters in slots 1 and up. Among
eligible requests, the lowest slot number always wins.

Slaves can answer with a two-cycle retry or split response. A split master
drops out of arbitration until its slave raises that master's bit on the
release vector. A retried master stays in contention. Locked sequences keep
the bus for one extra transfer after the lock drops. A locked transfer that is
split parks the bus on the placeholder master. Fixed-length incrementing and
wrapping bursts are counted beat by beat, and the grant is held until the
count runs out. Open-ended incrementing bursts are re-arbitrated every cycle.

The control state machine has five states:
- OPEN: arbitrates every cycle.
- BURST: entered on a counted burst start. It leaves on the last beat, on an
  early response, or on a change of owner.
- LOCKED: entered whenever the incoming master holds its lock line at a ready
  edge. It moves to TAIL when that line falls.
- TAIL: one extra transfer, then back to OPEN.
- PARK: entered when a locked transfer is split. It returns to OPEN when the
  parked master is released.

Top module: `ahb_split_arbiter`

## Requirements
- R1: During and just after reset, the grant selects the default master (parameter, default 1), the owner output equals that master, and the lock output is low.
- R2: The grant vector always has exactly one bit set.
- R3: In OPEN, the grant goes to the lowest-numbered requesting master in slots 1 and up that is not split; a request on slot 0 is ignored.
- R4: When no real master requests, the default master is granted, or slot 0 if the default master is split.
- R5: The owner and lock outputs change only at an edge where ready is high; there the owner takes the index of the grant held before that edge. In OPEN the grant may change while ready is low.
- R6: A split response (response code 3, seen in its first cycle with ready low) removes the data-phase master from arbitration from that edge on, until its bit on the release vector is high. If every requesting real master is split, slot 0 is granted.
- R7: A retry response (code 2) on an unlocked transfer leaves the retried master eligible, so it is granted again unless a lower-numbered master requests.
- R8: If the incoming master's lock line is high at a ready edge, the lock output is high for that address phase and the grant stays with that master. When its lock line falls, the lock output goes low and the master keeps the grant for one more transfer. Slot 0 never has the lock output high.
- R9: A split on a locked transfer grants slot 0 and keeps it granted until the split master is released. A retry on a locked transfer keeps the grant on the locked master regardless of priority.
- R10: Transfer type codes are idle 0, busy 1, first beat 2, and following beat 3. Burst codes are single 0, open incrementing 1, and then 2/3, 4/5, 6/7 for wrapping/incrementing bursts of 4, 8 and 16 beats. A first beat of a counted burst by the owning master, which also holds the grant, holds the grant until its last following beat is sampled. An open incrementing burst is arbitrated every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_MASTERS | Bus request per master |
| lock_i | input | NUM_MASTERS | Lock request per master |
| trans_i | input | 2 | Transfer type of the current address phase |
| burst_i | input | 3 | Burst type of the current address phase |
| resp_i | input | 2 | Slave response: okay 0, error 1, retry 2, split 3 |
| ready_i | input | 1 | Global transfer-ready |
| split_release_i | input | NUM_MASTERS | Per-master release from split slaves |
| grant_o | output | NUM_MASTERS | One-hot grant |
| owner_o | output | $clog2(NUM_MASTERS) | Index of the address-phase owner |
| mastlock_o | output | 1 | Current address phase is locked |

## Verification
A stale split mask shows up on grant_o in the cycle after the first response
cycle. Either a released master stays shut out in favour of slot 0, or a split
master wins again. A beat counter that is off by one moves the grant one edge
early or late at the end of a counted burst. A state machine stuck in LOCKED or
TAIL is caught by mastlock_o and by the late return to priority order one edge
after the lock falls. Each of these faults becomes visible at the ports within
one or two clock edges of its cause.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'd0,
        TR_BUSY   = 2'd1,
        TR_NONSEQ = 2'd2,
        TR_SEQ    = 2'd3
    } trans_e;

    typedef enum logic [1:0] {
        RS_OKAY  = 2'd0,
        RS_ERROR = 2'd1,
        RS_RETRY = 2'd2,
        RS_SPLIT = 2'd3
    } resp_e;

    typedef enum logic [2:0] {
        BT_SINGLE = 3'd0,
        BT_INCR   = 3'd1,
        BT_WRAP4  = 3'd2,
        BT_INCR4  = 3'd3,
        BT_WRAP8  = 3'd4,
        BT_INCR8  = 3'd5,
        BT_WRAP16 = 3'd6,
        BT_INCR16 = 3'd7
    } burst_e;

    typedef enum logic [2:0] {
        ST_OPEN   = 3'd0,
        ST_BURST  = 3'd1,
        ST_LOCKED = 3'd2,
        ST_TAIL   = 3'd3,
        ST_PARK   = 3'd4
    } arb_state_e;

    localparam int BEAT_W = 5;

    // Beats in a burst; open-ended and single both report one.
    function automatic logic [BEAT_W-1:0] burst_beats(input burst_e b);
        logic [BEAT_W-1:0] n;
        unique case (b)
            BT_WRAP4,  BT_INCR4:  n = BEAT_W'(4);
            BT_WRAP8,  BT_INCR8:  n = BEAT_W'(8);
            BT_WRAP16, BT_INCR16: n = BEAT_W'(16);
            default:              n = BEAT_W'(1);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/arb_priority_pick.sv
`timescale 1ns/1ps
module arb_priority_pick #(
    parameter int NUM_MASTERS = 16
) (
    input  logic [NUM_MASTERS-1:0] cand_i,
    output logic [NUM_MASTERS-1:0] win_o,
    output logic                   found_o
);
    // seen[i] is set when some lower slot already holds a candidate.
    logic [NUM_MASTERS:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_chain
        assign win_o[i]    = cand_i[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | cand_i[i];
    end

    assign found_o = seen[NUM_MASTERS];

endmodule

// File: rtl/arb_split_tracker.sv
`timescale 1ns/1ps
module arb_split_tracker #(
    parameter int NUM_MASTERS = 16,
    localparam int IDX_W = $clog2(NUM_MASTERS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_i,
    input  logic [IDX_W-1:0]       set_idx_i,
    input  logic [NUM_MASTERS-1:0] release_i,
    output logic [NUM_MASTERS-1:0] mask_next_o
);
    logic [NUM_MASTERS-1:0] mask_q;
    logic [NUM_MASTERS-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (set_i) begin
            set_vec[set_idx_i] = 1'b1;
        end
    end

    // Slot 0 can never be split; a release in the same cycle wins over a held bit.
    assign mask_next_o = (mask_q | set_vec) & ~release_i & ~NUM_MASTERS'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_next_o;
        end
    end

endmodule

// File: rtl/arb_beat_counter.sv
`timescale 1ns/1ps
module arb_beat_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             last_o
);
    logic [CNT_W-1:0] left_q;

    assign last_o = (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= load_val_i;
        end else if (dec_i && left_q != '0) begin
            left_q <= left_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/ahb_split_arbiter.sv
`timescale 1ns/1ps
module ahb_split_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS    = 16,
    parameter int DEFAULT_MASTER = 1,
    localparam int IDX_W = $clog2(NUM_MASTERS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [NUM_MASTERS-1:0] lock_i,
    input  logic [1:0]             trans_i,
    input  logic [2:0]             burst_i,
    input  logic [1:0]             resp_i,
    input  logic                   ready_i,
    input  logic [NUM_MASTERS-1:0] split_release_i,
    output logic [NUM_MASTERS-1:0] grant_o,
    output logic [IDX_W-1:0]       owner_o,
    output logic                   mastlock_o
);
    localparam logic [NUM_MASTERS-1:0] DUMMY_VEC   = NUM_MASTERS'(1);
    localparam logic [NUM_MASTERS-1:0] DEFAULT_VEC = NUM_MASTERS'(1) << DEFAULT_MASTER;

    function automatic logic [IDX_W-1:0] vec_to_idx(input logic [NUM_MASTERS-1:0] v);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (v[i]) idx = IDX_W'(i);
        end
        return idx;
    endfunction

    // State register contents
    arb_state_e             state_q, state_d;
    logic [NUM_MASTERS-1:0] grant_q, grant_d;
    logic [IDX_W-1:0]       park_q,  park_d;

    // Bus-phase registers
    logic [IDX_W-1:0]       owner_q;
    logic                   lock_q;
    logic [IDX_W-1:0]       data_owner_q;
    logic                   data_lock_q;

    // Decoded inputs
    trans_e                 trans;
    resp_e                  resp;
    burst_e                 burst;
    logic [IDX_W-1:0]       gidx;
    logic [BEAT_W-1:0]      beats_new;

    // Arbitration
    logic [NUM_MASTERS-1:0] mask_next;
    logic [NUM_MASTERS-1:0] real_req;
    logic [NUM_MASTERS-1:0] eligible;
    logic [NUM_MASTERS-1:0] win_vec;
    logic                   win_found;
    logic [NUM_MASTERS-1:0] arb_vec;

    // Control
    logic                   resp_first;
    logic                   split_set;
    logic                   start_burst;
    logic                   cnt_load;
    logic                   cnt_dec;
    logic                   cnt_last;
    logic                   gidx_locks;

    assign trans      = trans_e'(trans_i);
    assign resp       = resp_e'(resp_i);
    assign burst      = burst_e'(burst_i);
    assign gidx       = vec_to_idx(grant_q);
    assign beats_new  = burst_beats(burst);
    assign gidx_locks = lock_i[gidx] && (gidx != '0);

    assign resp_first = (resp != RS_OKAY) && !ready_i;
    assign split_set  = resp_first && (resp == RS_SPLIT) && (data_owner_q != '0);

    assign start_burst = (trans == TR_NONSEQ) && (beats_new > BEAT_W'(1))
                         && (gidx == owner_q) && (owner_q != '0);

    arb_split_tracker #(
        .NUM_MASTERS (NUM_MASTERS)
    ) split_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (split_set),
        .set_idx_i   (data_owner_q),
        .release_i   (split_release_i),
        .mask_next_o (mask_next)
    );

    assign real_req = req_i & ~DUMMY_VEC;
    assign eligible = real_req & ~mask_next;

    arb_priority_pick #(
        .NUM_MASTERS (NUM_MASTERS)
    ) pick_i (
        .cand_i  (eligible),
        .win_o   (win_vec),
        .found_o (win_found)
    );

    always_comb begin
        if (win_found) begin
            arb_vec = win_vec;
        end else if (|real_req) begin
            arb_vec = DUMMY_VEC;
        end else if (mask_next[DEFAULT_MASTER]) begin
            arb_vec = DUMMY_VEC;
        end else begin
            arb_vec = DEFAULT_VEC;
        end
    end

    arb_beat_counter #(
        .CNT_W (BEAT_W)
    ) beats_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (beats_new - BEAT_W'(1)),
        .dec_i      (cnt_dec),
        .last_o     (cnt_last)
    );

    // Next-state and next-grant decision
    always_comb begin
        state_d  = state_q;
        grant_d  = grant_q;
        park_d   = park_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;

        if (state_q == ST_PARK) begin
            if (!mask_next[park_q]) begin
                state_d = ST_OPEN;
                grant_d = arb_vec;
            end else begin
                grant_d = DUMMY_VEC;
            end
        end else if (resp_first) begin
            unique case (resp)
                RS_SPLIT: begin
                    if (data_lock_q) begin
                        state_d = ST_PARK;
                        park_d  = data_owner_q;
                        grant_d = DUMMY_VEC;
                    end else begin
                        state_d = ST_OPEN;
                        grant_d = arb_vec;
                    end
                end
                RS_RETRY: begin
                    state_d = ST_OPEN;
                    if (data_lock_q) begin
                        grant_d = NUM_MASTERS'(1) << data_owner_q;
                    end else begin
                        grant_d = arb_vec;
                    end
                end
                default: begin
                    state_d = ST_OPEN;
                    grant_d = arb_vec;
                end
            endcase
        end else if (ready_i) begin
            if (gidx_locks) begin
                state_d = ST_LOCKED;
                grant_d = grant_q;
            end else begin
                unique case (state_q)
                    ST_LOCKED: begin
                        state_d = ST_TAIL;
                        grant_d = grant_q;
                    end
                    ST_TAIL: begin
                        state_d = ST_OPEN;
                        grant_d = arb_vec;
                    end
                    ST_BURST: begin
                        if (trans == TR_SEQ && gidx == owner_q) begin
                            cnt_dec = 1'b1;
                            if (cnt_last) begin
                                state_d = ST_OPEN;
                                grant_d = arb_vec;
                            end else begin
                                grant_d = grant_q;
                            end
                        end else if (trans == TR_BUSY && gidx == owner_q) begin
                            grant_d = grant_q;
                        end else if (start_burst) begin
                            cnt_load = 1'b1;
                            grant_d  = grant_q;
                        end else begin
                            state_d = ST_OPEN;
                            grant_d = arb_vec;
                        end
                    end
                    default: begin
                        if (start_burst) begin
                            state_d  = ST_BURST;
                            cnt_load = 1'b1;
                            grant_d  = grant_q;
                        end else begin
                            state_d = ST_OPEN;
                            grant_d = arb_vec;
                        end
                    end
                endcase
            end
        end else if (state_q == ST_OPEN) begin
            grant_d = arb_vec;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            grant_q <= DEFAULT_VEC;
            park_q  <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
            park_q  <= park_d;
        end
    end

    // Bus-phase outputs: advance only on a ready edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q      <= IDX_W'(DEFAULT_MASTER);
            lock_q       <= 1'b0;
            data_owner_q <= '0;
            data_lock_q  <= 1'b0;
        end else if (ready_i) begin
            owner_q      <= gidx;
            lock_q       <= gidx_locks;
            data_owner_q <= owner_q;
            data_lock_q  <= lock_q;
        end
    end

    assign grant_o    = grant_q;
    assign owner_o    = owner_q;
    assign mastlock_o = lock_q;

endmodule

// File: rtl/arb_checker.sv
`timescale 1ns/1ps
module arb_checker #(
    parameter int NUM_MASTERS = 16,
    localparam int IDX_W = $clog2(NUM_MASTERS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ready_i,
    input logic [NUM_MASTERS-1:0] lock_i,
    input logic [NUM_MASTERS-1:0] grant_o,
    input logic [IDX_W-1:0]       owner_o,
    input logic                   mastlock_o
);
    logic [NUM_MASTERS-1:0] grant_prev;
    logic                   incoming_locks;

    always_ff @(posedge clk) begin
        grant_prev <= grant_o;
    end

    assign incoming_locks = |(lock_i & grant_o & ~NUM_MASTERS'(1));

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == 1); // R2

    AST_OWNER_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(owner_o)); // R5

    AST_LOCK_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(mastlock_o)); // R5

    AST_OWNER_FROM_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ready_i |=> grant_prev[owner_o]); // R5

    AST_LOCK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ready_i && incoming_locks |=> mastlock_o); // R8

    AST_LOCK_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ready_i && !incoming_locks |=> !mastlock_o); // R8

    AST_DUMMY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        owner_o == '0 |-> !mastlock_o); // R8

endmodule

bind ahb_split_arbiter arb_checker #(
    .NUM_MASTERS (NUM_MASTERS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_i    (ready_i),
    .lock_i     (lock_i),
    .grant_o    (grant_o),
    .owner_o    (owner_o),
    .mastlock_o (mastlock_o)
);

// File: tb/ahb_split_arbiter_tb_top.sv
`timescale 1ns/1ps
module ahb_split_arbiter_tb_top;

    localparam int N = 16;

    typedef struct packed {
        logic [15:0] req;
        logic [15:0] lock;
        logic        rdy;
        logic [3:0]  g;
        logic [3:0]  o;
        logic        l;
    } row_t;

    localparam int ROWS = 18;
    localparam row_t STIM [ROWS] = '{
        '{16'h0000, 16'h0000, 1'b1, 4'd1,  4'd1,  1'b0},
        '{16'h0028, 16'h0000, 1'b1, 4'd3,  4'd1,  1'b0},
        '{16'h0028, 16'h0000, 1'b1, 4'd3,  4'd3,  1'b0},
        '{16'h0020, 16'h0000, 1'b1, 4'd5,  4'd3,  1'b0},
        '{16'h0024, 16'h0000, 1'b1, 4'd2,  4'd5,  1'b0},
        '{16'h0000, 16'h0000, 1'b1, 4'd1,  4'd2,  1'b0},
        '{16'h0000, 16'h0000, 1'b1, 4'd1,  4'd1,  1'b0},
        '{16'h0010, 16'h0000, 1'b0, 4'd4,  4'd1,  1'b0},
        '{16'h0010, 16'h0000, 1'b0, 4'd4,  4'd1,  1'b0},
        '{16'h0010, 16'h0000, 1'b1, 4'd4,  4'd4,  1'b0},
        '{16'hC000, 16'h0000, 1'b1, 4'd14, 4'd4,  1'b0},
        '{16'h0001, 16'h0000, 1'b1, 4'd1,  4'd14, 1'b0},
        '{16'h0040, 16'h0040, 1'b1, 4'd6,  4'd1,  1'b0},
        '{16'h0044, 16'h0040, 1'b1, 4'd6,  4'd6,  1'b1},
        '{16'h0044, 16'h0040, 1'b1, 4'd6,  4'd6,  1'b1},
        '{16'h0044, 16'h0000, 1'b1, 4'd6,  4'd6,  1'b0},
        '{16'h0044, 16'h0000, 1'b1, 4'd2,  4'd6,  1'b0},
        '{16'h0004, 16'h0000, 1'b1, 4'd2,  4'd2,  1'b0}
    };

    localparam logic [1:0] T_IDLE = 2'd0, T_NSEQ = 2'd2, T_SEQ = 2'd3;
    localparam logic [2:0] B_SINGLE = 3'd0, B_INCR = 3'd1, B_INCR4 = 3'd3;
    localparam logic [1:0] R_OK = 2'd0, R_RETRY = 2'd2, R_SPLIT = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req, lock, rel;
    logic [1:0]    trans, resp;
    logic [2:0]    burst;
    logic          ready;
    logic [N-1:0]  grant;
    logic [3:0]    owner;
    logic          mlock;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    ahb_split_arbiter #(
        .NUM_MASTERS    (N),
        .DEFAULT_MASTER (1)
    ) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_i           (req),
        .lock_i          (lock),
        .trans_i         (trans),
        .burst_i         (burst),
        .resp_i          (resp),
        .ready_i         (ready),
        .split_release_i (rel),
        .grant_o         (grant),
        .owner_o         (owner),
        .mastlock_o      (mlock)
    );

    task automatic drive(input logic [15:0] rq, input logic [15:0] lk,
                         input logic [1:0] tr, input logic [2:0] bu,
                         input logic [1:0] rs, input logic rd,
                         input logic [15:0] sp);
        req = rq; lock = lk; trans = tr; burst = bu; resp = rs; ready = rd; rel = sp;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_state(input string tag, input int g, input int o, input logic l);
        logic [N-1:0] g_vec;
        g_vec = N'(1) << g;
        n_tests++;
        if (grant !== g_vec || owner !== 4'(o) || mlock !== l) begin
            n_fail++;
            $display("FAIL %s: grant=%h owner=%0d lock=%b expected grant=%h owner=%0d lock=%b",
                     tag, grant, owner, mlock, g_vec, o, l);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req = '0; lock = '0; rel = '0; trans = T_IDLE; burst = B_SINGLE; resp = R_OK; ready = 1'b1;
        repeat (3) @(negedge clk);
        expect_state("R1 in reset", 1, 1, 1'b0);
        rst_n = 1'b1;
        expect_state("R1 after reset", 1, 1, 1'b0);

        // Table walk: priority, default, wait states, lock with tail
        for (int i = 0; i < ROWS; i++) begin
            drive(STIM[i].req, STIM[i].lock, T_IDLE, B_SINGLE, R_OK, STIM[i].rdy, '0);
            expect_state($sformatf("R2 R3 R4 R5 R8 table row %0d", i),
                         int'(STIM[i].g), int'(STIM[i].o), STIM[i].l);
        end

        // R10: four-beat counted burst by master 2 holds against master 1
        drive(16'h0004, '0, T_NSEQ, B_INCR4, R_OK, 1'b1, '0);
        expect_state("R10 burst first beat", 2, 2, 1'b0);
        drive(16'h0006, '0, T_SEQ, B_INCR4, R_OK, 1'b1, '0);
        expect_state("R10 burst beat 2", 2, 2, 1'b0);
        drive(16'h0006, '0, T_SEQ, B_INCR4, R_OK, 1'b1, '0);
        expect_state("R10 burst beat 3", 2, 2, 1'b0);
        drive(16'h0006, '0, T_SEQ, B_INCR4, R_OK, 1'b1, '0);
        expect_state("R10 burst last beat releases", 1, 2, 1'b0);

        // R10: open incrementing burst is preempted at once
        drive(16'h0008, '0, T_IDLE, B_SINGLE, R_OK, 1'b1, '0);
        drive(16'h0008, '0, T_IDLE, B_SINGLE, R_OK, 1'b1, '0);
        expect_state("R10 setup owner 3", 3, 3, 1'b0);
        drive(16'h000C, '0, T_NSEQ, B_INCR, R_OK, 1'b1, '0);
        expect_state("R10 open burst rearbitrated", 2, 3, 1'b0);

        // R6: split of master 3
        drive(16'h0008, '0, T_IDLE, B_SINGLE, R_OK, 1'b1, '0);
        drive(16'h0008, '0, T_IDLE, B_SINGLE, R_OK, 1'b1, '0);
        drive(16'h0008, '0, T_NSEQ, B_SINGLE, R_OK, 1'b1, '0);
        expect_state("R6 setup", 3, 3, 1'b0);
        drive(16'h0028, '0, T_IDLE, B_SINGLE, R_SPLIT, 1'b0, '0);
        expect_state("R6 split first cycle moves grant", 5, 3, 1'b0);
        drive(16'h0028, '0, T_IDLE, B_SINGLE, R_SPLIT, 1'b1, '0);
        expect_state("R6 split second cycle", 5, 5, 1'b0);
        drive(16'h0008, '0, T_IDLE, B_SINGLE, R_OK, 1'b1, '0);
        expect_state("R6 all requesters split gives slot 0", 0, 5, 1'b0);
        drive(16'h0008, '0, T_IDLE, B_SINGLE, R_OK, 1'b1, 16'h0008);
        expect_state("R6 release restores master 3", 3, 0, 1'b0);

        // R7: unlocked retry keeps master 3 eligible
        drive(16'h0008, '0, T_IDLE, B_SINGLE, R_OK, 1'b1, '0);
        drive(16'h0008, '0, T_NSEQ, B_SINGLE, R_OK, 1'b1, '0);
        drive(16'h0028, '0, T_IDLE, B_SINGLE, R_RETRY, 1'b0, '0);
        expect_state("R7 retry first cycle", 3, 3, 1'b0);
        drive(16'h0028, '0, T_IDLE, B_SINGLE, R_RETRY, 1'b1, '0);
        expect_state("R7 retry second cycle", 3, 3, 1'b0);

        // R9: split on a locked transfer parks on slot 0
        drive(16'h0010, 16'h0010, T_IDLE, B_SINGLE, R_OK, 1'b1, '0);
        expect_state("R8 lock setup", 4, 3, 1'b0);
        drive(16'h0010, 16'h0010, T_IDLE, B_SINGLE, R_OK, 1'b1, '0);
        expect_state("R8 lock taken", 4, 4, 1'b1);
        drive(16'h0010, 16'h0010, T_NSEQ, B_SINGLE, R_OK, 1'b1, '0);
        drive(16'h0014, 16'h0010, T_IDLE, B_SINGLE, R_SPLIT, 1'b0, '0);
        expect_state("R9 locked split grants slot 0", 0, 4, 1'b1);
        drive(16'h0014, 16'h0010, T_IDLE, B_SINGLE, R_SPLIT, 1'b1, '0);
        expect_state("R9 parked second cycle", 0, 0, 1'b0);
        drive(16'h0014, 16'h0010, T_IDLE, B_SINGLE, R_OK, 1'b1, '0);
        expect_state("R9 stays parked", 0, 0, 1'b0);
        drive(16'h0014, 16'h0000, T_IDLE, B_SINGLE, R_OK, 1'b1, 16'h0010);
        expect_state("R9 release leaves park", 2, 0, 1'b0);

        // R9 and R8: retry on a locked transfer, then tail transfer
        drive(16'h0004, 16'h0004, T_IDLE, B_SINGLE, R_OK, 1'b1, '0);
        expect_state("R8 master 2 locks", 2, 2, 1'b1);
        drive(16'h0006, 16'h0004, T_NSEQ, B_SINGLE, R_OK, 1'b1, '0);
        drive(16'h0006, 16'h0004, T_IDLE, B_SINGLE, R_RETRY, 1'b0, '0);
        expect_state("R9 locked retry keeps grant", 2, 2, 1'b1);
        drive(16'h0006, 16'h0004, T_IDLE, B_SINGLE, R_RETRY, 1'b1, '0);
        expect_state("R9 locked retry second cycle", 2, 2, 1'b1);
        drive(16'h0006, 16'h0000, T_IDLE, B_SINGLE, R_OK, 1'b1, '0);
        expect_state("R8 lock drop keeps one more transfer", 2, 2, 1'b0);
        drive(16'h0006, 16'h0000, T_IDLE, B_SINGLE, R_OK, 1'b1, '0);
        expect_state("R8 after tail priority resumes", 1, 2, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule